// File: doc/BRIEF.md
# Reference Clock Switchover Controller

This block picks which of two reference clocks drives a downstream consumer such as a PLL input, and forwards that clock on `clk_o`. Everything runs in a free-running monitor clock domain. Each reference passes through a synchronizer, and an idle counter per input raises a loss-of-activity flag when no transition arrives within a programmable window. The selection can move for two reasons. An automatic failover fires when the chosen reference goes quiet. A qualified manual request fires from a user control line.

A 2-bit mode input picks the policy. In automatic mode the control line is ignored. In manual mode only the control line moves the selection. In override mode failover runs, but the control line can force a toggle, and while that line stays high it freezes the selection. After any switch a holdoff timer keeps failover from acting again at once, so two dead references alternate slowly rather than every cycle. The output clock is a plain AND-OR of the references with registered one-hot enables.

Top module: `refclk_switchover`

## Requirements
- R1: While reset is held and right after it is released, `activeclk_o` is 0, `clkbad_o` is 2'b00 and `sel_en_o` is 2'b01.
- R2: `clkbad_o[i]` goes to 1 once reference i has shown no transition for WINDOW (default 8) monitor cycles after synchronization. It returns to 0 within a few cycles of transitions resuming.
- R3: With `mode_i` = 2'b00 (automatic), if the selected reference is flagged bad and no holdoff is running, the selection moves to the other reference.
- R4: With `mode_i` = 2'b00, `clkswitch_i` has no effect on the selection.
- R5: With `mode_i` = 2'b01 (manual) or 2'b11 (reserved, same as manual), a rise of `clkswitch_i` held for at least 3 monitor cycles toggles the selection once. A high pulse of 2 cycles leaves the selection unchanged.
- R6: One request gives exactly one toggle, however long the line stays high. The line must go low before another request is accepted.
- R7: In manual mode the selection never changes because a reference is flagged bad.
- R8: With `mode_i` = 2'b10 (override), a qualified request toggles once. While `clkswitch_i` stays high, no failover happens even if the selected input is bad. Failover resumes once the line is low again.
- R9: After any change of selection, failover waits HOLDOFF (default 16) monitor cycles. With both references dead, the next change appears exactly 17 cycles after the previous one.
- R10: `sel_en_o` is one-hot, with bit 1 set exactly when `activeclk_o` is 1, and `clk_o` follows the reference that is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_mon_i | input | 1 | Free-running monitor clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 2 | The two reference clocks, index 0 and 1 |
| mode_i | input | 2 | 00 automatic, 01 manual, 10 override, 11 manual |
| clkswitch_i | input | 1 | Asynchronous manual switch request line |
| clk_o | output | 1 | Selected reference clock |
| activeclk_o | output | 1 | Index of the selected reference |
| sel_en_o | output | 2 | Registered one-hot enable of each reference |
| clkbad_o | output | 2 | Loss-of-activity flag of each reference |

## Verification
Failover is driven by stopping the selected reference alone, which separates correct monitoring of the selected input from a reaction to the idle one. Stopping both references at once separates a working holdoff timer from ping-ponging every cycle, and the bench samples at the exact cycle the timer expires. Control-line pulses of 2 cycles, 3 cycles and a long hold tell the qualification threshold and the one-shot behaviour apart in each mode. A long hold in override mode while the selected reference is dead shows that failover is blocked, and releasing the line shows that it resumes.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
    typedef enum logic [1:0] {
        MODE_AUTO     = 2'b00,
        MODE_MANUAL   = 2'b01,
        MODE_OVERRIDE = 2'b10,
        MODE_RSVD     = 2'b11
    } rcs_mode_e;
endpackage

// File: rtl/rcs_activity_mon.sv
module rcs_activity_mon #(
    parameter int unsigned WINDOW      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ref_i,
    output logic bad_o
);
    localparam int unsigned CW = $clog2(WINDOW + 1);

    typedef struct packed {
        logic [SYNC_STAGES:0] pipe;   // synchronizer stages plus one delayed copy
        logic [CW-1:0]        idle;
        logic                 bad;
    } mon_st_t;

    mon_st_t st_d, st_q;
    logic    edge_seen;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[SYNC_STAGES-1:0], ref_i};
        edge_seen = st_q.pipe[SYNC_STAGES] ^ st_q.pipe[SYNC_STAGES-1];
        if (edge_seen) begin
            st_d.idle = '0;
        end else if (st_q.idle != CW'(WINDOW)) begin
            st_d.idle = st_q.idle + 1'b1;
        end
        st_d.bad = (st_q.idle == CW'(WINDOW));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign bad_o = st_q.bad;
endmodule

// File: rtl/rcs_switch_qual.sv
module rcs_switch_qual #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned QUAL_CYCLES = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sw_i,
    output logic level_o,
    output logic req_o
);
    localparam int unsigned QW = $clog2(QUAL_CYCLES + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   armed;
        logic [QW-1:0]          cnt;
        logic                   req;
    } qual_st_t;

    qual_st_t st_d, st_q;
    logic     lvl;

    assign lvl = st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], sw_i};
        st_d.req  = 1'b0;
        if (!lvl) begin
            st_d.cnt   = '0;
            st_d.armed = 1'b1;
        end else if (st_q.armed) begin
            if (st_q.cnt == QW'(QUAL_CYCLES - 1)) begin
                st_d.req   = 1'b1;
                st_d.armed = 1'b0;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign level_o = lvl;
    assign req_o   = st_q.req;
endmodule

// File: rtl/refclk_switchover.sv
module refclk_switchover #(
    parameter int unsigned NUM_REF     = 2,
    parameter int unsigned WINDOW      = 8,
    parameter int unsigned HOLDOFF     = 16,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned QUAL_CYCLES = 3
) (
    input  logic       clk_mon_i,
    input  logic       rst_ni,
    input  logic [1:0] ref_clk_i,
    input  logic [1:0] mode_i,
    input  logic       clkswitch_i,
    output logic       clk_o,
    output logic       activeclk_o,
    output logic [1:0] sel_en_o,
    output logic [1:0] clkbad_o
);
    import rcs_pkg::*;

    localparam int unsigned HW = $clog2(HOLDOFF + 1);

    typedef struct packed {
        logic          sel;
        logic [1:0]    en;
        logic [HW-1:0] holdoff;
    } top_st_t;

    top_st_t   st_d, st_q;
    logic [1:0] bad;
    logic       sw_level;
    logic       sw_req;
    logic       man_ok, auto_ok, flip;
    rcs_mode_e  mode;

    for (genvar g = 0; g < NUM_REF; g++) begin : g_mon
        rcs_activity_mon #(
            .WINDOW      (WINDOW),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_mon (
            .clk_i  (clk_mon_i),
            .rst_ni (rst_ni),
            .ref_i  (ref_clk_i[g]),
            .bad_o  (bad[g])
        );
    end

    rcs_switch_qual #(
        .SYNC_STAGES (SYNC_STAGES),
        .QUAL_CYCLES (QUAL_CYCLES)
    ) u_qual (
        .clk_i   (clk_mon_i),
        .rst_ni  (rst_ni),
        .sw_i    (clkswitch_i),
        .level_o (sw_level),
        .req_o   (sw_req)
    );

    always_comb begin
        mode    = rcs_mode_e'(mode_i);
        man_ok  = (mode != MODE_AUTO);
        auto_ok = (mode == MODE_AUTO) || ((mode == MODE_OVERRIDE) && !sw_level);
        flip    = (man_ok && sw_req) ||
                  (auto_ok && (st_q.holdoff == '0) && bad[st_q.sel]);

        st_d     = st_q;
        st_d.sel = st_q.sel ^ flip;
        st_d.en  = st_d.sel ? 2'b10 : 2'b01;
        if (flip) begin
            st_d.holdoff = HW'(HOLDOFF);
        end else if (st_q.holdoff != '0) begin
            st_d.holdoff = st_q.holdoff - 1'b1;
        end
    end

    always_ff @(posedge clk_mon_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.sel     <= 1'b0;
            st_q.en      <= 2'b01;
            st_q.holdoff <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_o       = |(ref_clk_i & st_q.en);
    assign activeclk_o = st_q.sel;
    assign sel_en_o    = st_q.en;
    assign clkbad_o    = bad;
endmodule

// File: rtl/refclk_switchover_chk.sv
module refclk_switchover_chk #(
    parameter int unsigned HOLDOFF = 16
) (
    input logic       clk_mon_i,
    input logic       rst_ni,
    input logic [1:0] ref_clk_i,
    input logic [1:0] mode_i,
    input logic       clkswitch_i,
    input logic       activeclk_o,
    input logic [1:0] sel_en_o,
    input logic [1:0] clkbad_o
);
    localparam int unsigned GW = $clog2(HOLDOFF + 1);

    logic          prev_q;
    logic [GW-1:0] gap_q;
    logic          changed;

    assign changed = (activeclk_o != prev_q);

    always_ff @(posedge clk_mon_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= 1'b0;
            gap_q  <= GW'(HOLDOFF);
        end else begin
            prev_q <= activeclk_o;
            if (changed)                    gap_q <= '0;
            else if (gap_q != GW'(HOLDOFF)) gap_q <= gap_q + 1'b1;
        end
    end

    a_r10_en_onehot: assert property (@(posedge clk_mon_i) disable iff (!rst_ni)
        $countones(sel_en_o) == 1);

    a_r10_en_tracks_sel: assert property (@(posedge clk_mon_i) disable iff (!rst_ni)
        sel_en_o[1] == activeclk_o);

    a_r9_holdoff_gap: assert property (@(posedge clk_mon_i) disable iff (!rst_ni)
        (changed && ($past(mode_i) == 2'b00)) |-> (gap_q >= GW'(HOLDOFF)));

    a_r8_override_freeze: assert property (@(posedge clk_mon_i) disable iff (!rst_ni)
        (($past(mode_i) == 2'b10) && $past(clkswitch_i, 1) && $past(clkswitch_i, 2) &&
         $past(clkswitch_i, 3) && $past(clkswitch_i, 4) && $past(clkswitch_i, 5) &&
         $past(clkswitch_i, 6) && $past(clkswitch_i, 7)) |-> !changed);

    a_r7_manual_needs_request: assert property (@(posedge clk_mon_i) disable iff (!rst_ni)
        (changed && ($past(mode_i) inside {2'b01, 2'b11})) |-> $past(clkswitch_i, 4));

    for (genvar g = 0; g < 2; g++) begin : g_idle
        a_r2_bad_after_idle: assert property (@(posedge clk_mon_i) disable iff (!rst_ni)
            $rose(clkbad_o[g]) |->
                (($past(ref_clk_i[g], 1) == $past(ref_clk_i[g], 2)) &&
                 ($past(ref_clk_i[g], 2) == $past(ref_clk_i[g], 3)) &&
                 ($past(ref_clk_i[g], 3) == $past(ref_clk_i[g], 4)) &&
                 ($past(ref_clk_i[g], 4) == $past(ref_clk_i[g], 5))));
    end
endmodule

bind refclk_switchover refclk_switchover_chk #(.HOLDOFF(HOLDOFF)) u_chk (
    .clk_mon_i   (clk_mon_i),
    .rst_ni      (rst_ni),
    .ref_clk_i   (ref_clk_i),
    .mode_i      (mode_i),
    .clkswitch_i (clkswitch_i),
    .activeclk_o (activeclk_o),
    .sel_en_o    (sel_en_o),
    .clkbad_o    (clkbad_o)
);

// File: tb/refclk_switchover_bench.sv
`timescale 1ns/1ps
module refclk_switchover_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       r0 = 1'b0, r1 = 1'b0;
    logic       run0 = 1'b1, run1 = 1'b1;
    logic [1:0] ref_clk;
    logic [1:0] mode;
    logic       clkswitch;
    logic       clk_out, activeclk;
    logic [1:0] sel_en, clkbad;

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        string      tag;
        logic       sel;
        logic [1:0] bad;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;
    always #10 if (run0) r0 = ~r0;
    always #12 if (run1) r1 = ~r1;
    assign ref_clk = {r1, r0};

    refclk_switchover u_refclk_switchover (
        .clk_mon_i   (clk),
        .rst_ni      (rst_n),
        .ref_clk_i   (ref_clk),
        .mode_i      (mode),
        .clkswitch_i (clkswitch),
        .clk_o       (clk_out),
        .activeclk_o (activeclk),
        .sel_en_o    (sel_en),
        .clkbad_o    (clkbad)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // driver side: push an expected state for the monitor
    task automatic expect_state(input string tag, input logic sel, input logic [1:0] bad);
        exp_t e;
        e.tag = tag; e.sel = sel; e.bad = bad;
        @(negedge clk);
        sb_q.push_back(e);
        repeat (2) @(negedge clk);
    endtask

    // monitor side: compare queued expectations with the outputs
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " sel"}, {3'b0, activeclk}, {3'b0, e.sel});
                check({e.tag, " bad"}, {2'b0, clkbad},    {2'b0, e.bad});
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int n);
        @(negedge clk);
        clkswitch = 1'b1;
        repeat (n) @(negedge clk);
        clkswitch = 1'b0;
    endtask

    task automatic check_clk_out(input string tag, input int idx);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(tag, {3'b0, clk_out}, {3'b0, ref_clk[idx]});
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #100000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; mode = 2'b00; clkswitch = 1'b0;
        wait_cyc(5);
        check("R1 sel in reset", {3'b0, activeclk}, 4'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 sel", {3'b0, activeclk}, 4'h0);
        check("R1 bad", {2'b0, clkbad}, 4'h0);
        check("R1 en",  {2'b0, sel_en}, 4'h1);

        wait_cyc(10);
        check_clk_out("R10 clk_o follows ref0", 0);

        // automatic failover
        run0 = 1'b0;
        wait_cyc(30);
        expect_state("R3 failover to ref1", 1'b1, 2'b01);
        check("R10 en after failover", {2'b0, sel_en}, 4'h2);
        check_clk_out("R10 clk_o follows ref1", 1);
        run0 = 1'b1;
        wait_cyc(20);
        expect_state("R2 flag clears", 1'b1, 2'b00);

        // automatic mode ignores the control line
        pulse(5);
        wait_cyc(12);
        expect_state("R4 clkswitch ignored", 1'b1, 2'b00);

        // manual mode
        mode = 2'b01;
        wait_cyc(3);
        pulse(2);
        wait_cyc(12);
        expect_state("R5 two-cycle pulse rejected", 1'b1, 2'b00);
        pulse(3);
        wait_cyc(12);
        expect_state("R5 three-cycle pulse toggles", 1'b0, 2'b00);
        @(negedge clk);
        clkswitch = 1'b1;
        wait_cyc(40);
        expect_state("R6 long hold toggles once", 1'b1, 2'b00);
        clkswitch = 1'b0;
        wait_cyc(5);
        pulse(3);
        wait_cyc(12);
        expect_state("R6 rearmed after low", 1'b0, 2'b00);
        run0 = 1'b0;
        wait_cyc(30);
        expect_state("R7 no failover in manual", 1'b0, 2'b01);
        mode = 2'b11;
        pulse(4);
        wait_cyc(12);
        expect_state("R5 reserved code acts as manual", 1'b1, 2'b01);
        run0 = 1'b1;
        wait_cyc(20);
        expect_state("R2 flag clears again", 1'b1, 2'b00);

        // override mode
        @(negedge clk);
        mode = 2'b10;
        clkswitch = 1'b1;
        wait_cyc(12);
        expect_state("R8 request toggles once", 1'b0, 2'b00);
        run0 = 1'b0;
        wait_cyc(30);
        expect_state("R8 failover blocked while high", 1'b0, 2'b01);
        clkswitch = 1'b0;
        wait_cyc(12);
        expect_state("R8 failover after release", 1'b1, 2'b01);
        run0 = 1'b1;
        wait_cyc(20);
        expect_state("R8 recovered", 1'b1, 2'b00);

        // holdoff with both references dead
        mode = 2'b00;
        wait_cyc(20);
        run0 = 1'b0;
        run1 = 1'b0;
        begin
            logic s0, s1, stable;
            int   t;
            s0 = activeclk;
            t  = 0;
            while (activeclk == s0 && t < 200) begin
                @(negedge clk);
                t++;
            end
            check("R3 first switch with both dead", {3'b0, activeclk}, {3'b0, ~s0});
            s1 = activeclk;
            stable = 1'b1;
            repeat (16) begin
                @(negedge clk);
                if (activeclk != s1) stable = 1'b0;
            end
            check("R9 held during holdoff", {3'b0, stable}, 4'h1);
            @(negedge clk);
            check("R9 switch when holdoff ends", {3'b0, activeclk}, {3'b0, ~s1});
        end
        check("R2 both flagged", {2'b0, clkbad}, 4'h3);
        run0 = 1'b1;
        run1 = 1'b1;
        wait_cyc(20);
        check("R2 both clear", {2'b0, clkbad}, 4'h0);

        wait_cyc(4);
        finish_run();
    end
endmodule